// File: doc/BRIEF.md
# Variable-Step Up/Down Wrap Counter

A 16-bit counter that moves up or down on every rising clock edge, by either one or a 4-bit programmable amount. It also accepts a synchronous parallel load and an asynchronous clear.

It does not use modular arithmetic. A step that would carry past the all-ones value puts the count at zero. A step that would borrow below zero puts the count at all-ones. The count only ever jumps straight to the opposite end of its range. It never lands at some remainder beyond that end.

The clear takes effect at once. Its release passes through a two-stage synchronizer, so loads and counting resume only on the third rising edge after the clear input goes high. The block is meant for address sequencers and test-pattern walkers that need fixed strides with hard end-of-range jumps.

Top module: `var_step_wrap_counter`

## Requirements
- R1: While `clear_n` is low, `count_q` is 0, and it becomes 0 as soon as `clear_n` falls, without waiting for a clock edge.
- R2: After `clear_n` rises, the first two rising edges leave `count_q` at 0 and ignore `load_en`. The third rising edge is the first that loads or counts.
- R3: When `load_en` is 1 at an active rising edge, `count_q` takes `load_value`. This takes priority over counting.
- R4: `count_up` = 1 adds the step and `count_up` = 0 subtracts it, on every active edge that has no load. There is no separate enable.
- R5: With `step_sel` = 0 the step is 1 whatever `step_amt` holds. With `step_sel` = 1 the step is `step_amt` as an unsigned value: from 0 upward by 3, the count runs 3, 6, 9.
- R6: Counting up, if `count_q` is 16'hFFFF or the 17-bit sum of count and step exceeds 16'hFFFF, the next value is 0. For example, 16'hFFFE with step 4 gives 0.
- R7: Counting down, if `count_q` is 0 or the step is larger than `count_q`, the next value is 16'hFFFF. For example, from 9 by 4 the count runs 5, 1, 16'hFFFF.
- R8: With `step_sel` = 1 and `step_amt` = 0, `count_q` holds, except that 16'hFFFF counting up gives 0 and 0 counting down gives 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Asynchronous active-low clear, released synchronously |
| load_en | input | 1 | Parallel load request |
| load_value | input | 16 | Value taken on a load |
| count_up | input | 1 | Direction: 1 counts up, 0 counts down |
| step_sel | input | 1 | 1 selects `step_amt` as the step, 0 selects a step of 1 |
| step_amt | input | 4 | Programmable step size |
| count_q | output | 16 | Current count |

## Verification
The checker watches every cycle for these properties:
- the clear forcing zero and the count staying at zero until the synchronized release;
- a load landing on the next edge;
- the jumps at both ends of the range;
- the step-of-zero hold;
- an exact stride on every count that does not reach an end.

Some behaviour only the bench's scenarios can show:
- the exact three-edge delay after release;
- a clear that falls between clock edges;
- the documented sequences, such as 9, 5, 1, 16'hFFFF and 0, 3, 6, 9.

The bench also drives long random runs whose values are biased toward both ends of the range. These runs show that the carry and borrow tests agree with a bench model built on integer arithmetic.

// File: rtl/vswc_pkg.sv
package vswc_pkg;

  localparam int unsigned COUNT_W_DEF = 16;
  localparam int unsigned STEP_W_DEF  = 4;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

endpackage

// File: rtl/vswc_rst_sync.sv
module vswc_rst_sync #(
  parameter int unsigned STAGES = vswc_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic clear_n,
  output logic run_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign run_o = chain_q[STAGES-1];

endmodule

// File: rtl/vswc_step_sel.sv
module vswc_step_sel #(
  parameter int unsigned COUNT_W = vswc_pkg::COUNT_W_DEF,
  parameter int unsigned STEP_W  = vswc_pkg::STEP_W_DEF
) (
  input  logic               step_sel,
  input  logic [STEP_W-1:0]  step_amt,
  output logic [COUNT_W-1:0] step_o
);

  localparam int unsigned PAD_W = COUNT_W - STEP_W;

  logic [COUNT_W-1:0] amt_ext;
  logic [COUNT_W-1:0] unit_step;

  assign amt_ext   = {{PAD_W{1'b0}}, step_amt};
  assign unit_step = {{(COUNT_W-1){1'b0}}, 1'b1};

  always_comb begin
    if (step_sel) begin
      step_o = amt_ext;
    end else begin
      step_o = unit_step;
    end
  end

endmodule

// File: rtl/vswc_wrap_arith.sv
module vswc_wrap_arith
  import vswc_pkg::*;
#(
  parameter int unsigned COUNT_W = vswc_pkg::COUNT_W_DEF
) (
  input  logic [COUNT_W-1:0] cur_i,
  input  logic [COUNT_W-1:0] step_i,
  input  dir_e               dir_i,
  output logic [COUNT_W-1:0] next_o
);

  localparam logic [COUNT_W-1:0] TOP_VAL = {COUNT_W{1'b1}};
  localparam logic [COUNT_W-1:0] BOT_VAL = '0;

  logic [COUNT_W:0]   sum_ext;
  logic [COUNT_W:0]   diff_ext;
  logic               at_top;
  logic               at_bot;
  logic               up_wrap;
  logic               dn_wrap;
  logic [COUNT_W-1:0] up_val;
  logic [COUNT_W-1:0] dn_val;

  always_comb begin
    sum_ext  = {1'b0, cur_i} + {1'b0, step_i};
    diff_ext = {1'b0, cur_i} - {1'b0, step_i};
    at_top   = (cur_i == TOP_VAL);
    at_bot   = (cur_i == BOT_VAL);
    up_wrap  = at_top | sum_ext[COUNT_W];
    dn_wrap  = at_bot | diff_ext[COUNT_W];
    up_val   = up_wrap ? BOT_VAL : sum_ext[COUNT_W-1:0];
    dn_val   = dn_wrap ? TOP_VAL : diff_ext[COUNT_W-1:0];
  end

  always_comb begin
    unique case (dir_i)
      DIR_UP:   next_o = up_val;
      DIR_DOWN: next_o = dn_val;
      default:  next_o = up_val;
    endcase
  end

endmodule

// File: rtl/var_step_wrap_counter.sv
module var_step_wrap_counter
  import vswc_pkg::*;
#(
  parameter int unsigned COUNT_W = vswc_pkg::COUNT_W_DEF,
  parameter int unsigned STEP_W  = vswc_pkg::STEP_W_DEF
) (
  input  logic               clk,
  input  logic               clear_n,
  input  logic               load_en,
  input  logic [COUNT_W-1:0] load_value,
  input  logic               count_up,
  input  logic               step_sel,
  input  logic [STEP_W-1:0]  step_amt,
  output logic [COUNT_W-1:0] count_q
);

  logic               run_active;
  logic [COUNT_W-1:0] step_w;
  logic [COUNT_W-1:0] arith_next;
  logic [COUNT_W-1:0] cnt_d;
  logic [COUNT_W-1:0] cnt_q;
  logic               cnt_en;
  dir_e               dir_w;

  vswc_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .clear_n (clear_n),
    .run_o   (run_active)
  );

  vswc_step_sel #(
    .COUNT_W (COUNT_W),
    .STEP_W  (STEP_W)
  ) u_step (
    .step_sel (step_sel),
    .step_amt (step_amt),
    .step_o   (step_w)
  );

  assign dir_w = count_up ? DIR_UP : DIR_DOWN;

  vswc_wrap_arith #(
    .COUNT_W (COUNT_W)
  ) u_arith (
    .cur_i  (cnt_q),
    .step_i (step_w),
    .dir_i  (dir_w),
    .next_o (arith_next)
  );

  always_comb begin
    cnt_en = run_active;
    if (load_en) begin
      cnt_d = load_value;
    end else begin
      cnt_d = arith_next;
    end
  end

  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_q = cnt_q;

endmodule

// File: rtl/vswc_checker.sv
module vswc_checker #(
  parameter int unsigned COUNT_W = 16,
  parameter int unsigned STEP_W  = 4
) (
  input logic               clk,
  input logic               clear_n,
  input logic               run_active,
  input logic               load_en,
  input logic [COUNT_W-1:0] load_value,
  input logic               count_up,
  input logic               step_sel,
  input logic [STEP_W-1:0]  step_amt,
  input logic [COUNT_W-1:0] count_q
);

  localparam logic [COUNT_W-1:0] TOP_VAL = {COUNT_W{1'b1}};

  logic [COUNT_W:0] eff_step;
  logic [COUNT_W:0] cnt_ext;
  logic             counting;

  assign eff_step = step_sel ? {{(COUNT_W+1-STEP_W){1'b0}}, step_amt}
                             : {{COUNT_W{1'b0}}, 1'b1};
  assign cnt_ext  = {1'b0, count_q};
  assign counting = run_active && !load_en;

  always @(negedge clk) begin
    if (!clear_n) begin
      assert_clear_zero_R1: assert (count_q == '0);
    end
  end

  assert_held_before_run_R2: assert property (@(posedge clk) disable iff (!clear_n)
    !run_active |=> count_q == '0);

  assert_load_taken_R3: assert property (@(posedge clk) disable iff (!clear_n)
    run_active && load_en |=> count_q == $past(load_value));

  assert_up_stride_R4: assert property (@(posedge clk) disable iff (!clear_n)
    counting && count_up && count_q != TOP_VAL && (cnt_ext + eff_step) <= {1'b0, TOP_VAL}
    |=> {1'b0, count_q} == $past(cnt_ext) + $past(eff_step));

  assert_down_stride_R5: assert property (@(posedge clk) disable iff (!clear_n)
    counting && !count_up && count_q != '0 && eff_step <= cnt_ext
    |=> {1'b0, count_q} == $past(cnt_ext) - $past(eff_step));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!clear_n)
    counting && count_up && (count_q == TOP_VAL || (cnt_ext + eff_step) > {1'b0, TOP_VAL})
    |=> count_q == '0);

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!clear_n)
    counting && !count_up && (count_q == '0 || eff_step > cnt_ext)
    |=> count_q == TOP_VAL);

  assert_zero_step_hold_R8: assert property (@(posedge clk) disable iff (!clear_n)
    counting && step_sel && step_amt == '0 && count_q != '0 && count_q != TOP_VAL
    |=> $stable(count_q));

endmodule

bind var_step_wrap_counter vswc_checker #(
  .COUNT_W (COUNT_W),
  .STEP_W  (STEP_W)
) u_vswc_checker (
  .clk        (clk),
  .clear_n    (clear_n),
  .run_active (run_active),
  .load_en    (load_en),
  .load_value (load_value),
  .count_up   (count_up),
  .step_sel   (step_sel),
  .step_amt   (step_amt),
  .count_q    (count_q)
);

// File: tb/var_step_wrap_counter_tb_top.sv
`timescale 1ns/1ps
module var_step_wrap_counter_tb_top;

  logic        clk;
  logic        clear_n;
  logic        load_en;
  logic [15:0] load_value;
  logic        count_up;
  logic        step_sel;
  logic [3:0]  step_amt;
  logic [15:0] count_q;

  int unsigned n_checks;
  int unsigned n_errors;
  int unsigned rel_edges;
  logic [15:0] exp_q;
  logic        done;

  var_step_wrap_counter dut_i (
    .clk        (clk),
    .clear_n    (clear_n),
    .load_en    (load_en),
    .load_value (load_value),
    .count_up   (count_up),
    .step_sel   (step_sel),
    .step_amt   (step_amt),
    .count_q    (count_q)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] model_next(input logic [15:0] cur, input logic ld,
      input logic [15:0] val, input logic up, input logic sel, input logic [3:0] amt);
    int c;
    int s;
    c = int'(cur);
    s = sel ? int'(amt) : 1;
    if (ld) return val;
    if (up) begin
      if (c == 65535 || c + s > 65535) return 16'h0000;
      return 16'(c + s);
    end
    if (c == 0 || s > c) return 16'hFFFF;
    return 16'(c - s);
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] expv, input string tag);
    n_checks++;
    if (act !== expv) begin
      n_errors++;
      $display("FAIL %s: count_q=%h expected=%h at %0t", tag, act, expv, $time);
    end
  endtask

  // Called at a negedge: drives inputs, lets one rising edge pass, checks at the next negedge.
  task automatic apply(input logic ld, input logic [15:0] val, input logic up,
      input logic sel, input logic [3:0] amt, input string tag);
    load_en    = ld;
    load_value = val;
    count_up   = up;
    step_sel   = sel;
    step_amt   = amt;
    if (rel_edges >= 2) exp_q = model_next(exp_q, ld, val, up, sel, amt);
    rel_edges++;
    @(negedge clk);
    check(count_q, exp_q, tag);
  endtask

  task automatic release_clear();
    clear_n = 1'b1;
    rel_edges = 0;
    exp_q = 16'h0000;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: count_q=%h expected=completion", count_q);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_init;
    n_checks = 0;
    n_errors = 0;
    done = 1'b0;
    rel_edges = 0;
    exp_q = '0;
    clear_n = 1'b0;
    load_en = 1'b0;
    load_value = '0;
    count_up = 1'b1;
    step_sel = 1'b0;
    step_amt = '0;
    seed_init = $urandom(32'd2024);

    #5;
    check(count_q, 16'h0000, "R1 reset state");
    @(negedge clk);
    release_clear();
    // R2: two edges after release ignore load
    apply(1'b1, 16'h1234, 1'b1, 1'b0, 4'd0, "R2 first edge");
    apply(1'b1, 16'h1234, 1'b1, 1'b0, 4'd0, "R2 second edge");
    apply(1'b1, 16'h1234, 1'b1, 1'b0, 4'd0, "R3 load after release");

    // R5: stride 3 from zero, step_sel=0 ignores amt
    apply(1'b1, 16'h0000, 1'b1, 1'b1, 4'd3, "R3 load zero");
    apply(1'b0, 16'h0000, 1'b1, 1'b1, 4'd3, "R5 stride3 a");
    apply(1'b0, 16'h0000, 1'b1, 1'b1, 4'd3, "R5 stride3 b");
    apply(1'b0, 16'h0000, 1'b1, 1'b1, 4'd3, "R5 stride3 c");
    apply(1'b0, 16'h0000, 1'b1, 1'b0, 4'd15, "R5 unit step");
    apply(1'b0, 16'h0000, 1'b0, 1'b0, 4'd15, "R4 down unit");

    // R7: 9 by 4 down
    apply(1'b1, 16'd9, 1'b0, 1'b1, 4'd4, "R3 load nine");
    apply(1'b0, 16'd0, 1'b0, 1'b1, 4'd4, "R7 nine to five");
    apply(1'b0, 16'd0, 1'b0, 1'b1, 4'd4, "R7 five to one");
    apply(1'b0, 16'd0, 1'b0, 1'b1, 4'd4, "R7 one to top");
    apply(1'b0, 16'd0, 1'b1, 1'b0, 4'd0, "R6 top plus one");
    apply(1'b0, 16'd0, 1'b0, 1'b0, 4'd0, "R7 zero minus one");

    // R6: FFFE + 4
    apply(1'b1, 16'hFFFE, 1'b1, 1'b1, 4'd4, "R3 load FFFE");
    apply(1'b0, 16'h0000, 1'b1, 1'b1, 4'd4, "R6 FFFE plus four");
    apply(1'b1, 16'hFFFC, 1'b1, 1'b1, 4'd3, "R3 load FFFC");
    apply(1'b0, 16'h0000, 1'b1, 1'b1, 4'd3, "R6 exact fit to FFFF");

    // R8: zero step
    apply(1'b1, 16'h1234, 1'b1, 1'b1, 4'd0, "R3 load 1234");
    apply(1'b0, 16'h0000, 1'b1, 1'b1, 4'd0, "R8 hold up");
    apply(1'b0, 16'h0000, 1'b0, 1'b1, 4'd0, "R8 hold down");
    apply(1'b1, 16'hFFFF, 1'b1, 1'b1, 4'd0, "R3 load FFFF");
    apply(1'b0, 16'h0000, 1'b1, 1'b1, 4'd0, "R8 top zero step up");
    apply(1'b0, 16'h0000, 1'b0, 1'b1, 4'd0, "R8 bottom zero step down");

    // R1/R2: clear between edges
    apply(1'b1, 16'h0F0F, 1'b1, 1'b0, 4'd0, "R3 load 0F0F");
    #4 clear_n = 1'b0;
    #2 check(count_q, 16'h0000, "R1 async clear");
    @(negedge clk);
    check(count_q, 16'h0000, "R1 held in clear");
    release_clear();
    apply(1'b0, 16'h0000, 1'b1, 1'b1, 4'd5, "R2 no count edge one");
    apply(1'b0, 16'h0000, 1'b1, 1'b1, 4'd5, "R2 no count edge two");
    apply(1'b0, 16'h0000, 1'b1, 1'b1, 4'd5, "R4 first count after release");

    // R9-style random mix against the model
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] v;
      int unsigned pick;
      pick = $urandom % 4;
      if (pick == 0) v = 16'($urandom % 16);
      else if (pick == 1) v = 16'hFFF0 | 16'($urandom % 16);
      else v = 16'($urandom);
      apply(($urandom % 12) == 0, v, 1'($urandom), 1'($urandom), 4'($urandom),
            "R4 random count");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule